// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block owns the output latches of a bank of quasi-bidirectional I/O pins and turns each latch into the drive enables of a pad. Each pin gets three enables: a strong pull-down, a strong pull-up that fires as a short pulse, and a weak keeper pull-up. A latch at 0 sinks the pin hard. A latch that rises from 0 to 1 gives the pin a brief strong push high and then leaves only the keeper holding it. The pad's analog strengths are outside the block. Only the enables come out of it.

The bank has three pin classes. Key-scan style port pins give a two-clock strong pull-up and read back their latch. Register-mapped general pins give a one-clock strong pull-up and read back the pin level, through a two-flop synchronizer. LED-style open-drain pins never drive high strongly and read back their latch. Software writes any subset of the latches in one cycle, using a bit mask.

Top module: `pod_port_driver`

## Requirements
- R1: After reset every latch holds 1. Every pin then shows pull-down 0, strong pull-up 0 and keeper 1. Every read bit is 1.
- R2: One cycle after a latch is written 0, that pin shows pull-down 1, strong pull-up 0 and keeper 0.
- R3: Bits [3:0] are key-scan pins. When one of their latches is written from 0 to 1, the strong pull-up is 1 for exactly the two cycles after the write, with the keeper 0. After that the keeper is 1 and the strong pull-up is 0.
- R4: Bits [5:4] are register-mapped pins. When one of their latches goes from 0 to 1, the strong pull-up is 1 for exactly one cycle after the write, and then the keeper takes over.
- R5: Writing 1 to a latch that already holds 1 starts no strong pull-up pulse.
- R6: Bits [7:6] are LED-style pins. Their strong pull-up is never 1. Their keeper equals their latch.
- R7: Read data for key-scan and LED pins equals the latch, whatever the pin level is.
- R8: Read data for register-mapped pins equals pin_i, delayed by two clock edges.
- R9: A write changes only the latches whose wr_mask_i bit is 1.
- R10: Writing 0 while a strong pull-up pulse is running ends the pulse on the next cycle. The pin then shows pull-down only.
- R11: On every pin, exactly one of pull-down, strong pull-up and keeper is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oscillator period per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Latch write strobe |
| wr_mask_i | input | 8 | Per-pin write select |
| wr_data_i | input | 8 | Value written to the selected latches |
| pin_i | input | 8 | Sensed pad levels |
| pull_dn_o | output | 8 | Strong pull-down enables |
| boost_o | output | 8 | Strong pull-up pulse enables |
| keep_o | output | 8 | Weak keeper enables |
| rd_data_o | output | 8 | Read-back data per pin |

## Verification
The bench targets the pulse length of each class. A class whose counter is loaded with the wrong value gives a strong pull-up that is one cycle short or one cycle long. It also writes 1 over latches that already hold 1. A design that keys the pulse on the write strobe instead of on the latch edge would pulse again there. It writes 0 in the middle of a pulse. A design that keeps counting would drive high and low at the same time. It drives pin levels that disagree with the latches, with a mask that covers only some pins. A design that picks the wrong read source, skips a synchronizer stage or ignores the mask shows a mismatched read bit.

// File: rtl/pod_pkg.sv
package pod_pkg;
  typedef enum logic [1:0] {PC_KEYSCAN, PC_REGMAP, PC_LED} pin_class_e;

  function automatic pin_class_e class_of(int idx, int n_ks, int n_gp);
    if (idx < n_ks) return PC_KEYSCAN;
    if (idx < n_ks + n_gp) return PC_REGMAP;
    return PC_LED;
  endfunction

  function automatic int boost_len(pin_class_e c, int ks_len, int gp_len);
    case (c)
      PC_KEYSCAN: return ks_len;
      PC_REGMAP:  return gp_len;
      default:    return 0;
    endcase
  endfunction

  function automatic bit reads_pin(pin_class_e c);
    return c == PC_REGMAP;
  endfunction
endpackage

// File: rtl/pod_sync.sv
module pod_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pod_pin_cell.sv
module pod_pin_cell #(
  parameter int BOOST_CYC = 2,
  parameter bit READ_PIN  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic data_i,
  input  logic pin_sync_i,
  output logic pull_dn_o,
  output logic boost_o,
  output logic keep_o,
  output logic rd_o
);
  localparam int CW = (BOOST_CYC > 0) ? $clog2(BOOST_CYC + 1) : 1;

  logic          latch_q, latch_d;
  logic [CW-1:0] cnt_q;

  assign latch_d = wr_i ? data_i : latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      latch_q <= latch_d;
      if (latch_d && !latch_q)
        cnt_q <= CW'(BOOST_CYC);        // rising latch arms the pulse
      else if (!latch_d)
        cnt_q <= '0;                    // low drive cancels any pulse
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pull_dn_o = ~latch_q;
  assign boost_o   = (cnt_q != '0);
  assign keep_o    = latch_q & ~boost_o;
  assign rd_o      = READ_PIN ? pin_sync_i : latch_q;
endmodule

// File: rtl/pod_port_driver.sv
module pod_port_driver #(
  parameter int N_KS     = 4,
  parameter int N_GP     = 2,
  parameter int N_LED    = 2,
  parameter int KS_BOOST = 2,
  parameter int GP_BOOST = 1,
  localparam int N       = N_KS + N_GP + N_LED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wr_mask_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pull_dn_o,
  output logic [N-1:0] boost_o,
  output logic [N-1:0] keep_o,
  output logic [N-1:0] rd_data_o
);
  import pod_pkg::*;

  logic [N-1:0] pin_sync;

  pod_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    localparam pin_class_e PC = class_of(i, N_KS, N_GP);
    pod_pin_cell #(
      .BOOST_CYC(boost_len(PC, KS_BOOST, GP_BOOST)),
      .READ_PIN (reads_pin(PC))
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i & wr_mask_i[i]),
      .data_i    (wr_data_i[i]),
      .pin_sync_i(pin_sync[i]),
      .pull_dn_o (pull_dn_o[i]),
      .boost_o   (boost_o[i]),
      .keep_o    (keep_o[i]),
      .rd_o      (rd_data_o[i])
    );
  end
endmodule

// File: rtl/pod_port_driver_chk.sv
module pod_port_driver_chk #(
  parameter int N_KS  = 4,
  parameter int N_GP  = 2,
  parameter int N_LED = 2,
  localparam int N    = N_KS + N_GP + N_LED
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] pull_dn_o,
  input logic [N-1:0] boost_o,
  input logic [N-1:0] keep_o,
  input logic [N-1:0] rd_data_o
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    // R11
    one_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({pull_dn_o[i], boost_o[i], keep_o[i]}) == 1);
    // R5
    boost_from_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(boost_o[i]) |-> $past(pull_dn_o[i]));
    if (i < N_KS) begin : g_ks
      // R3
      ks_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(boost_o[i]) |=> (boost_o[i] || pull_dn_o[i])));
      // R7
      ks_read_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[i] == !pull_dn_o[i]);
    end else if (i < N_KS + N_GP) begin : g_gp
      // R4
      gp_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(boost_o[i]) |=> !boost_o[i]);
    end else begin : g_led
      // R6
      led_no_boost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boost_o[i]);
      // R7
      led_read_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[i] == keep_o[i]);
    end
  end
endmodule

bind pod_port_driver pod_port_driver_chk #(
  .N_KS (N_KS),
  .N_GP (N_GP),
  .N_LED(N_LED)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pull_dn_o(pull_dn_o),
  .boost_o  (boost_o),
  .keep_o   (keep_o),
  .rd_data_o(rd_data_o)
);

// File: tb/tb_pod_port_driver.sv
module tb_pod_port_driver;
  localparam int N = 8;

  typedef struct {
    string      rid;
    logic [N-1:0] dn, bo, kp, rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0;
  logic [N-1:0] wr_mask_i = '0, wr_data_i = '0, pin_i = '1;
  logic [N-1:0] pull_dn_o, boost_o, keep_o, rd_data_o;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];

  // reference state built from the requirements
  logic [N-1:0] m_lat = '1, m_s1 = '1, m_s2 = '1;
  int m_cnt [N];

  always #10 clk = ~clk;

  pod_port_driver dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_mask_i(wr_mask_i),
    .wr_data_i(wr_data_i), .pin_i(pin_i), .pull_dn_o(pull_dn_o),
    .boost_o(boost_o), .keep_o(keep_o), .rd_data_o(rd_data_o)
  );

  function automatic int blen(int i);
    if (i < 4) return 2;
    if (i < 6) return 1;
    return 0;
  endfunction

  task automatic cyc(input bit w, input logic [N-1:0] m, input logic [N-1:0] d,
                     input logic [N-1:0] p, input string rid);
    logic [N-1:0] nl;
    exp_t e;
    @(negedge clk);
    wr_i = w; wr_mask_i = m; wr_data_i = d; pin_i = p;
    @(posedge clk);
    nl = w ? ((m & d) | (~m & m_lat)) : m_lat;
    for (int i = 0; i < N; i++) begin
      if (!nl[i]) m_cnt[i] = 0;
      else if (!m_lat[i]) m_cnt[i] = blen(i);
      else if (m_cnt[i] > 0) m_cnt[i]--;
    end
    m_lat = nl;
    m_s2 = m_s1;
    m_s1 = p;
    e.rid = rid;
    e.dn = ~m_lat;
    for (int i = 0; i < N; i++) e.bo[i] = (m_cnt[i] != 0);
    e.kp = m_lat & ~e.bo;
    e.rd = (m_lat & 8'hCF) | (m_s2 & 8'h30);
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pull_dn_o !== e.dn || boost_o !== e.bo || keep_o !== e.kp || rd_data_o !== e.rd) begin
        failures++;
        $display("FAIL %s: dn/bo/kp/rd act=%h/%h/%h/%h exp=%h/%h/%h/%h", e.rid,
                 pull_dn_o, boost_o, keep_o, rd_data_o, e.dn, e.bo, e.kp, e.rd);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (pull_dn_o !== '0 || boost_o !== '0 || keep_o !== '1 || rd_data_o !== '1) begin
      failures++;
      $display("FAIL R1: dn/bo/kp/rd act=%h/%h/%h/%h exp=00/00/ff/ff",
               pull_dn_o, boost_o, keep_o, rd_data_o);
    end
    cyc(0, '0, '0, '1, "R1");
    cyc(1, '1, '1, '1, "R5");          // 1 over 1: no pulse
    cyc(0, '0, '0, '1, "R5");
    cyc(1, '1, '0, '1, "R2");          // all low
    cyc(0, '0, '0, '1, "R2");
    cyc(1, '1, '1, '1, "R3 R4 R6");    // all rise
    cyc(0, '0, '0, '1, "R3 R4");
    cyc(0, '0, '0, '1, "R3");
    cyc(0, '0, '0, '1, "R11");
    cyc(1, 8'h55, 8'h00, '1, "R9");    // only masked pins drop
    cyc(1, 8'h55, 8'h55, '1, "R9 R3");
    cyc(1, 8'h01, 8'h00, '1, "R10");   // kill pulse on bit0
    cyc(0, '0, '0, '1, "R10");
    cyc(0, '0, '0, '1, "R10");
    cyc(0, '0, '0, 8'h00, "R7 R8");     // pins low
    cyc(0, '0, '0, 8'h00, "R8");
    cyc(0, '0, '0, 8'h00, "R8 R7");
    cyc(0, '0, '0, 8'h10, "R8");
    cyc(0, '0, '0, 8'h20, "R8");
    cyc(0, '0, '0, 8'h20, "R8");
    cyc(1, 8'hC0, 8'h40, 8'h30, "R6 R7");
    cyc(1, 8'hC0, 8'hC0, 8'h30, "R6");
    cyc(1, 8'h30, 8'h00, 8'h30, "R8 R2");
    cyc(1, 8'h30, 8'h10, 8'h30, "R4");
    cyc(0, '0, '0, 8'h30, "R4");
    cyc(1, 8'h01, 8'h01, '1, "R5 R3");
    cyc(1, 8'h01, 8'h01, '1, "R5");
    cyc(0, '0, '0, '1, "R3");
    cyc(0, '0, '0, '1, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule